// File: doc/BRIEF.md
# Single-Wire Bus Search Step Engine

This block carries out one decision step of the device-address search on a single-wire open-drain bus. When started, it runs two read slots, the first giving the current address bit and the second its complement. From the two values it picks a branch and then writes that branch bit back on the bus, so that every device whose address differs on this bit stops taking part in the search.

When both branches exist on the bus, the block takes the branch from a direction input that the caller supplies. When both read slots come back high, no device answered. The step then ends with an error status, no write slot follows, and the caller must restart the search. The caller runs the outer loop over all address bits and keeps track of discrepancies. It also issues the bus reset before a search begins.

All slot timing is produced inside the block from clock-cycle parameters:

- the low time of a write-1 or read slot,
- the low time of a write-0 slot,
- the sample point,
- the total slot length.

The block only drives a pull-low enable. It reads the bus level back through a synchroniser.

Top module: `ow_search_triplet`

## Requirements
- R1: After reset, `pullLow`, `busy` and `done` are 0 and `status` is 3'b000.
- R2: A step starts with two read slots. Each read slot pulls the line low for exactly LOW_ONE_CYC cycles, and the line level is taken at the SAMPLE_CYC point of the slot. The first slot gives the ID bit and the second gives the complement bit.
- R3: If the ID bit and the complement bit are both 1, the step ends after the two read slots with status 3'b011, and no write slot is issued.
- R4: If both bits are 0, the branch is the `dirReq` value latched at start. The status is 3'b100 for a branch of 1 and 3'b000 for a branch of 0.
- R5: If exactly one bit is 1, the branch equals the ID bit and `dirReq` has no effect. The status is 3'b101 when the ID bit is 1 and 3'b010 when the complement bit is 1.
- R6: After a valid decision, a third slot writes the branch bit. It pulls the line low for LOW_ZERO_CYC cycles when the branch is 0 and for LOW_ONE_CYC cycles when the branch is 1.
- R7: Each slot lasts SLOT_CYC cycles, measured from one pull-low start to the next.
- R8: `done` is a one-cycle pulse raised once the last slot has ended, with `busy` already low. `status` changes only together with `done` and holds its value until the next `done`. The status bits are: bit 0 is the ID bit, bit 1 is the complement bit, and bit 2 is the branch taken.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. It does not change the latched direction or the slot sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins one search step when idle |
| dirReq | input | 1 | Branch to take when both values are present |
| lineIn | input | 1 | Bus level, asynchronous |
| pullLow | output | 1 | Open-drain pull-low enable |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {branch, complement bit, ID bit} |

## Verification
The bench models devices whose address bit is 0, 1 or both, so that it covers all four read outcomes and each value of the direction input.

- **Branch choice.** A design that took the direction input in the single-branch cases, or wrote a branch after the error case, would show a wrong status or a third slot.
- **Write slot.** The low-time width of the write slot is measured. A swapped write-0/write-1 timing shows up there.
- **Slot period.** The period between pull-low starts is measured. An off-by-one slot counter shows up there.
- **Start while busy.** A second start pulse during a step, carrying a different direction, exposes a design that re-latches the direction or restarts the step.
- **Held status.** The status is checked to stay the same after the done pulse.

// File: rtl/ow_triplet_pkg.sv
package ow_triplet_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic runSlot;     // a slot is in progress
    logic clrCnt;      // restart the slot timer
    logic latchReq;    // capture the requested direction
    logic capId;       // capture first read
    logic capComp;     // capture second read
    logic useZeroLow;  // current slot uses the long low time
    logic loadStatus;  // update the status register
  } ctrlStrobe_t;

  // flags from the datapath back to the control
  typedef struct packed {
    logic atSample;
    logic atEnd;
    logic bothOnes;
    logic dirBit;
  } dpFlags_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} stepState_t;

endpackage

// File: rtl/ow_triplet_dp.sv
module ow_triplet_dp
  import ow_triplet_pkg::*;
#(
  parameter int unsigned LOW_ONE_CYC  = 1200,
  parameter int unsigned LOW_ZERO_CYC = 12000,
  parameter int unsigned SAMPLE_CYC   = 3000,
  parameter int unsigned SLOT_CYC     = 14000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lineIn,
  input  logic        dirReq,
  input  ctrlStrobe_t strb,
  output dpFlags_t    flags,
  output logic        pullLow,
  output logic [2:0]  status
);

  localparam int unsigned CNT_W = $clog2(SLOT_CYC + 1);
  localparam logic [CNT_W-1:0] SMP_AT  = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] END_AT  = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_ONE = CNT_W'(LOW_ONE_CYC);
  localparam logic [CNT_W-1:0] LOW_ZER = CNT_W'(LOW_ZERO_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       slotCnt;
  logic                   idBit;
  logic                   compBit;
  logic                   reqQ;
  logic                   lineS;
  logic [CNT_W-1:0]       lowLen;

  // bus level synchroniser, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  // slot timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            slotCnt <= '0;
    else if (strb.clrCnt)  slotCnt <= '0;
    else if (strb.runSlot) slotCnt <= slotCnt + 1'b1;
  end

  // captured bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idBit   <= 1'b0;
      compBit <= 1'b0;
      reqQ    <= 1'b0;
    end else begin
      if (strb.latchReq) reqQ    <= dirReq;
      if (strb.capId)    idBit   <= lineS;
      if (strb.capComp)  compBit <= lineS;
    end
  end

  assign flags.atSample = strb.runSlot && (slotCnt == SMP_AT);
  assign flags.atEnd    = strb.runSlot && (slotCnt == END_AT);
  assign flags.bothOnes = idBit & compBit;
  assign flags.dirBit   = (idBit ^ compBit) ? idBit : reqQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               status <= 3'b000;
    else if (strb.loadStatus) status <= {flags.dirBit & ~flags.bothOnes, compBit, idBit};
  end

  assign lowLen  = strb.useZeroLow ? LOW_ZER : LOW_ONE;
  assign pullLow = strb.runSlot && (slotCnt < lowLen);

endmodule

// File: rtl/ow_triplet_ctrl.sv
module ow_triplet_ctrl
  import ow_triplet_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);

  localparam logic [1:0] SLOT_ID   = 2'd0;
  localparam logic [1:0] SLOT_COMP = 2'd1;
  localparam logic [1:0] SLOT_DIR  = 2'd2;

  stepState_t state;
  logic [1:0] slotIdx;
  logic       finishing;

  assign finishing = (state == ST_ACTIVE) && flags.atEnd &&
                     ((slotIdx == SLOT_DIR) || ((slotIdx == SLOT_COMP) && flags.bothOnes));

  always_comb begin
    strb            = '0;
    strb.runSlot    = (state == ST_ACTIVE);
    strb.latchReq   = (state == ST_IDLE) && start;
    strb.clrCnt     = ((state == ST_IDLE) && start) ||
                      ((state == ST_ACTIVE) && flags.atEnd && !finishing);
    strb.capId      = flags.atSample && (slotIdx == SLOT_ID);
    strb.capComp    = flags.atSample && (slotIdx == SLOT_COMP);
    strb.useZeroLow = (slotIdx == SLOT_DIR) && !flags.dirBit;
    strb.loadStatus = finishing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      slotIdx <= SLOT_ID;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state   <= ST_ACTIVE;
          slotIdx <= SLOT_ID;
        end
      end else if (finishing) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else if (flags.atEnd) begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

  assign busy = (state == ST_ACTIVE);

endmodule

// File: rtl/ow_search_triplet.sv
module ow_search_triplet
  import ow_triplet_pkg::*;
#(
  parameter int unsigned LOW_ONE_CYC  = 1200,
  parameter int unsigned LOW_ZERO_CYC = 12000,
  parameter int unsigned SAMPLE_CYC   = 3000,
  parameter int unsigned SLOT_CYC     = 14000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dirReq,
  input  logic       lineIn,
  output logic       pullLow,
  output logic       busy,
  output logic       done,
  output logic [2:0] status
);

  ctrlStrobe_t strb;
  dpFlags_t    flags;

  ow_triplet_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .flags (flags),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  ow_triplet_dp #(
    .LOW_ONE_CYC  (LOW_ONE_CYC),
    .LOW_ZERO_CYC (LOW_ZERO_CYC),
    .SAMPLE_CYC   (SAMPLE_CYC),
    .SLOT_CYC     (SLOT_CYC)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lineIn  (lineIn),
    .dirReq  (dirReq),
    .strb    (strb),
    .flags   (flags),
    .pullLow (pullLow),
    .status  (status)
  );

endmodule

// File: rtl/ow_search_triplet_chk.sv
module ow_search_triplet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pullLow,
  input logic       busy,
  input logic       done,
  input logic [2:0] status
);

  // R2
  pull_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pullLow |-> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($stable(status) || $past(done) || done));

  // R3
  err_no_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[1:0] == 2'b11) |-> !status[2]);

  // R5
  id_one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[1:0] == 2'b01) |-> status[2]);

  // R5
  comp_one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[1:0] == 2'b10) |-> !status[2]);

endmodule

bind ow_search_triplet ow_search_triplet_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pullLow (pullLow),
  .busy    (busy),
  .done    (done),
  .status  (status)
);

// File: tb/ow_search_triplet_tb.sv
`timescale 1ns/1ps
module ow_search_triplet_tb;

  localparam int unsigned L1  = 4;
  localparam int unsigned L0  = 20;
  localparam int unsigned SMP = 9;
  localparam int unsigned SL  = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dirReq = 1'b0;
  logic       lineIn;
  logic       pullLow;
  logic       busy;
  logic       done;
  logic [2:0] status;

  int checks = 0;
  int fails  = 0;

  // device population: has0 = some device with bit 0, has1 = some with bit 1
  logic has0 = 1'b0;
  logic has1 = 1'b0;

  // monitor state
  int monSlots = 0;
  int lowW [0:3];
  int riseAt [0:3];
  int cyc = 0;
  logic prevPl = 1'b0;

  always #2.5 clk = ~clk;

  ow_search_triplet #(
    .LOW_ONE_CYC (L1), .LOW_ZERO_CYC (L0), .SAMPLE_CYC (SMP), .SLOT_CYC (SL)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .dirReq (dirReq),
    .lineIn (lineIn), .pullLow (pullLow), .busy (busy), .done (done),
    .status (status)
  );

  // wired-AND bus: devices with a 0 pull low in the first read slot,
  // devices with a 1 pull low in the second read slot
  assign lineIn = !pullLow && !(monSlots == 1 && has0) && !(monSlots == 2 && has1);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pullLow && !prevPl) begin
      if (monSlots < 4) riseAt[monSlots] = cyc;
      monSlots = monSlots + 1;
    end
    if (pullLow && monSlots >= 1 && monSlots <= 4) lowW[monSlots-1] = lowW[monSlots-1] + 1;
    prevPl = pullLow;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expStatus(input logic h0, input logic h1, input logic d);
    logic idB, cpB;
    idB = !h0;
    cpB = !h1;
    if (idB && cpB)        return 3'b011;
    else if (!idB && !cpB) return {d, 2'b00};
    else                   return {idB, cpB, idB};
  endfunction

  task automatic clearMon();
    monSlots = 0;
    for (int i = 0; i < 4; i++) begin lowW[i] = 0; riseAt[i] = 0; end
  endtask

  // run one step; optionally pulse start again mid-step with the opposite direction
  task automatic runStep(input logic h0, input logic h1, input logic d,
                         input bit poke, input string req);
    logic [2:0] exp;
    int nSlots, waitN;
    bit seen;
    exp = expStatus(h0, h1, d);
    nSlots = (exp[1:0] == 2'b11) ? 2 : 3;
    @(negedge clk);
    has0 = h0; has1 = h1;
    clearMon();
    dirReq = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    waitN = 0;
    while (!seen && waitN < 5 * SL) begin
      if (poke && waitN == SL + 3) begin dirReq = !d; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      waitN++;
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk(req, seen, 1, "done seen");
    chk(req, busy, 0, "busy low at done");
    chk(req, status, exp, "status");
    chk("R3", monSlots, nSlots, "slot count");
    chk("R2", lowW[0], L1, "id slot low width");
    chk("R2", lowW[1], L1, "comp slot low width");
    chk("R7", riseAt[1] - riseAt[0], SL, "slot period");
    if (nSlots == 3) begin
      chk("R6", lowW[2], exp[2] ? L1 : L0, "write slot low width");
      chk("R7", riseAt[2] - riseAt[1], SL, "write slot period");
    end
    @(negedge clk);
    chk("R8", done, 0, "done one cycle");
    repeat (5) @(negedge clk);
    chk("R8", status, exp, "status held");
    chk("R8", monSlots, nSlots, "no extra slot after done");
  endtask

  task automatic testReset();
    chk("R1", pullLow, 0, "pullLow in reset");
    chk("R1", busy, 0, "busy in reset");
    chk("R1", done, 0, "done in reset");
    chk("R1", status, 0, "status in reset");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runStep(1'b0, 1'b0, 1'b0, 1'b0, "R3");  // no device: error
    runStep(1'b1, 1'b1, 1'b1, 1'b0, "R4");  // both present, go 1
    runStep(1'b1, 1'b1, 1'b0, 1'b0, "R4");  // both present, go 0
    runStep(1'b0, 1'b1, 1'b0, 1'b0, "R5");  // only ones, dir ignored
    runStep(1'b1, 1'b0, 1'b1, 1'b0, "R5");  // only zeros, dir ignored
    runStep(1'b1, 1'b1, 1'b1, 1'b1, "R9");  // restart attempt while busy
    runStep(1'b0, 1'b0, 1'b1, 1'b0, "R3");  // error after a valid step
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule